// File: doc/BRIEF.md
# Edge Pulse Link with Refresh

This block carries a single logic level across a channel that can only pass short pulses, such as a transformer-coupled barrier. A transmitter turns every change of its input into a one-clock pulse on one of two lines: one line means "now high", the other means "now low". A receiver holds the level in a bistable latch that changes only when one of these pulses arrives.

A pulse-only channel loses the level if a pulse is missed, so the transmitter also repeats the current level on a fixed quiet interval. The receiver runs a watchdog. When the far side stops sending, the watchdog drops the output enable and clears the level, which is the safe disconnected state. The enable leaves that state only when a valid pulse arrives.

All timing is counted in bit times of a shared-rate local clock. `CLKS_PER_BIT` is 8 for full speed and 64 for low speed at 96 MHz. The refresh interval is `REFRESH_BITS` bit times, 12 by default. The watchdog limit is `WATCHDOG_BITS` bit times, 30 by default, which keeps the release inside 32 bit times. The two channel lines are separate ports, so they can be looped back or driven on their own.

Top module: `edge_pulse_link`

## Requirements
- R1: When `dataIn` rises, `txSet` is high for exactly one cycle. That cycle is the one after the clock edge that first samples the new value. `txRst` stays low during that cycle.
- R2: When `dataIn` falls, `txRst` is high for exactly one cycle. That cycle is the one after the clock edge that first samples the new value. `txSet` stays low during that cycle.
- R3: After any transmitted pulse, if `dataIn` stays unchanged, a refresh pulse follows after REFRESH_BITS*CLKS_PER_BIT clocks (96 by default). A high level is refreshed on `txSet` and a low level on `txRst`. The refresh repeats at that same period for as long as the input is steady.
- R4: A pulse on `rxSet` alone sets `rxLevel`=1 and `rxDrive`=1 after the next edge. A pulse on `rxRst` alone sets `rxLevel`=0 and `rxDrive`=1. With no pulse, the latch holds its value.
- R5: While `rstN` is low, `rxDrive`, `rxLevel`, `txSet` and `txRst` are all 0. Once `rxDrive` is 0, it returns to 1 only on a valid single pulse.
- R6: When `rxSet` and `rxRst` are high in the same cycle, the receiver ignores both. The latch does not change and the watchdog does not restart.
- R7: If no valid pulse arrives for WATCHDOG_BITS*CLKS_PER_BIT clocks (240 by default), `rxDrive` and `rxLevel` fall to 0. This happens at the edge that completes that count, within 32 bit times.
- R8: With `txSet`/`txRst` looped back to `rxSet`/`rxRst`, `rxLevel` follows `dataIn` two edges after the change. `rxDrive` stays 1 for as long as the transmitter runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared-rate local clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 1 | Level to be carried across the link |
| txSet | output | 1 | One-cycle pulse meaning the level is high |
| txRst | output | 1 | One-cycle pulse meaning the level is low |
| rxSet | input | 1 | Received high pulse from the channel |
| rxRst | input | 1 | Received low pulse from the channel |
| rxLevel | output | 1 | Latched received level, 0 when disconnected |
| rxDrive | output | 1 | Output enable, 0 means high impedance or disconnected |

## Verification
The assertions check the following on every cycle:
- each input edge produces a matching pulse on the next cycle;
- every pulse encodes the level sampled one cycle before;
- the gap between pulses never reaches the refresh period;
- the receive enable never outlives the watchdog window;
- the latch rises only after a valid single pulse.

Some behaviour needs the bench's scenarios:
- the exact cycle at which each refresh pulse lands;
- that a conflicting pulse pair leaves the watchdog deadline where it was;
- that the output stays disconnected after a timeout;
- that the looped-back link keeps its enable up indefinitely through refresh alone.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // Strobes from receive control to the receive latch
  typedef struct packed {
    logic loadHigh;  // valid high pulse seen
    logic loadLow;   // valid low pulse seen
    logic goIdle;    // watchdog expired, fall to safe state
  } rxStrobes_t;

endpackage

// File: rtl/epl_tx.sv
module epl_tx #(
  parameter int REFRESH_CLKS = 96
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  output logic txSet,
  output logic txRst
);
  localparam int CW = (REFRESH_CLKS > 1) ? $clog2(REFRESH_CLKS) : 1;
  localparam logic [CW-1:0] QUIET_LAST = CW'(REFRESH_CLKS - 1);

  logic          lastLvl;
  logic [CW-1:0] quietCnt;
  logic          edgeSeen;
  logic          refreshDue;
  logic          sendNow;

  always_comb begin
    edgeSeen   = dataIn ^ lastLvl;
    refreshDue = (quietCnt == QUIET_LAST);
    sendNow    = edgeSeen | refreshDue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLvl  <= dataIn;
      quietCnt <= '0;
      txSet    <= 1'b0;
      txRst    <= 1'b0;
    end else begin
      lastLvl  <= dataIn;
      quietCnt <= sendNow ? '0 : quietCnt + CW'(1);
      txSet    <= sendNow & dataIn;
      txRst    <= sendNow & ~dataIn;
    end
  end

endmodule

// File: rtl/epl_rx_ctrl.sv
module epl_rx_ctrl
  import epl_pkg::*;
#(
  parameter int WD_CLKS = 240
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSet,
  input  logic       rxRst,
  output rxStrobes_t strb
);
  localparam int WW = (WD_CLKS > 1) ? $clog2(WD_CLKS) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(WD_CLKS - 1);

  logic [WW-1:0] wdCnt;
  logic          validPulse;
  logic          expired;

  always_comb begin
    validPulse    = rxSet ^ rxRst;
    expired       = (wdCnt == WD_LAST);
    strb.loadHigh = rxSet & ~rxRst;
    strb.loadLow  = rxRst & ~rxSet;
    strb.goIdle   = expired & ~validPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt <= WD_LAST;
    end else if (validPulse) begin
      wdCnt <= '0;
    end else if (!expired) begin
      wdCnt <= wdCnt + WW'(1);
    end
  end

endmodule

// File: rtl/epl_rx_data.sv
module epl_rx_data
  import epl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobes_t strb,
  output logic       rxLevel,
  output logic       rxDrive
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLevel <= 1'b0;
      rxDrive <= 1'b0;
    end else if (strb.loadHigh) begin
      rxLevel <= 1'b1;
      rxDrive <= 1'b1;
    end else if (strb.loadLow) begin
      rxLevel <= 1'b0;
      rxDrive <= 1'b1;
    end else if (strb.goIdle) begin
      rxLevel <= 1'b0;
      rxDrive <= 1'b0;
    end
  end

endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link
  import epl_pkg::*;
#(
  parameter int CLKS_PER_BIT  = 8,
  parameter int REFRESH_BITS  = 12,
  parameter int WATCHDOG_BITS = 30
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  output logic txSet,
  output logic txRst,
  input  logic rxSet,
  input  logic rxRst,
  output logic rxLevel,
  output logic rxDrive
);
  localparam int REFRESH_CLKS = REFRESH_BITS * CLKS_PER_BIT;
  localparam int WD_CLKS      = WATCHDOG_BITS * CLKS_PER_BIT;

  rxStrobes_t rxStrb;

  epl_tx #(.REFRESH_CLKS(REFRESH_CLKS)) uTx (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .txSet(txSet), .txRst(txRst)
  );

  epl_rx_ctrl #(.WD_CLKS(WD_CLKS)) uRxCtrl (
    .clk(clk), .rstN(rstN), .rxSet(rxSet), .rxRst(rxRst), .strb(rxStrb)
  );

  epl_rx_data uRxData (
    .clk(clk), .rstN(rstN), .strb(rxStrb), .rxLevel(rxLevel), .rxDrive(rxDrive)
  );

endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int REFRESH_CLKS = 96,
  parameter int WD_CLKS      = 240
) (
  input logic clk,
  input logic rstN,
  input logic dataIn,
  input logic txSet,
  input logic txRst,
  input logic rxSet,
  input logic rxRst,
  input logic rxLevel,
  input logic rxDrive
);
  int txQuiet;
  int sinceValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQuiet    <= 0;
      sinceValid <= 0;
    end else begin
      if (txSet || txRst)         txQuiet <= 0;
      else if (txQuiet < 1000000) txQuiet <= txQuiet + 1;
      if (rxSet ^ rxRst)             sinceValid <= 0;
      else if (sinceValid < 1000000) sinceValid <= sinceValid + 1;
    end
  end

  p_set_on_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataIn) |=> (txSet && !txRst));

  p_rst_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataIn) |=> (txRst && !txSet));

  p_refresh_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(txSet || txRst) |-> (txQuiet < REFRESH_CLKS));

  p_pulse_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txSet || txRst) |-> (txSet == $past(dataIn)));

  p_latch_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxLevel) |-> $past(rxSet && !rxRst));

  p_leave_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDrive) |-> $past(rxSet ^ rxRst));

  p_conflict_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxSet && rxRst) |=> (!$rose(rxLevel) && !$rose(rxDrive)));

  p_watchdog_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDrive |-> (sinceValid < WD_CLKS));

endmodule

bind edge_pulse_link epl_checker #(
  .REFRESH_CLKS(REFRESH_CLKS),
  .WD_CLKS(WD_CLKS)
) uChk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .txSet(txSet), .txRst(txRst),
  .rxSet(rxSet), .rxRst(rxRst), .rxLevel(rxLevel), .rxDrive(rxDrive)
);

// File: tb/sim_edge_pulse_link.sv
module sim_edge_pulse_link;
  localparam int REFRESH_CLKS = 96;
  localparam int WD_CLKS      = 240;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic manSet = 1'b0, manRst = 1'b0, loopEn = 1'b0;
  logic txSet, txRst, rxLevel, rxDrive;
  logic rxSet, rxRst;

  int nChecks = 0;
  int nFails  = 0;

  assign rxSet = loopEn ? txSet : manSet;
  assign rxRst = loopEn ? txRst : manRst;

  always #2 clk = ~clk;

  edge_pulse_link u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .txSet(txSet), .txRst(txRst),
    .rxSet(rxSet), .rxRst(rxRst), .rxLevel(rxLevel), .rxDrive(rxDrive)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic quietWindow(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txSet || txRst) bad++;
    end
    chkEq(req, bad, 0);
  endtask

  task automatic rxPulse(input logic s, input logic r);
    manSet = s; manRst = r;
    @(negedge clk);
    manSet = 1'b0; manRst = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    chkEq("R5 reset rxDrive", rxDrive, 0);
    chkEq("R5 reset rxLevel", rxLevel, 0);
    chkEq("R5 reset txSet", txSet, 0);
    chkEq("R5 reset txRst", txRst, 0);
    rstN = 1'b1;
  endtask

  task automatic tEdgesAndRefresh();
    @(negedge clk); dataIn = 1'b1;
    @(negedge clk);
    chkEq("R1 set pulse on rise", txSet, 1);
    chkEq("R1 no reset pulse on rise", txRst, 0);
    @(negedge clk);
    chkEq("R1 set pulse one cycle", txSet, 0);
    dataIn = 1'b0;
    @(negedge clk);
    chkEq("R2 reset pulse on fall", txRst, 1);
    chkEq("R2 no set pulse on fall", txSet, 0);
    quietWindow("R3 quiet before low refresh", REFRESH_CLKS - 1);
    @(negedge clk);
    chkEq("R3 low refresh on txRst", txRst, 1);
    dataIn = 1'b1;
    @(negedge clk);
    chkEq("R1 set after refresh", txSet, 1);
    quietWindow("R3 quiet before high refresh", REFRESH_CLKS - 1);
    @(negedge clk);
    chkEq("R3 high refresh on txSet", txSet, 1);
    quietWindow("R3 quiet second period", REFRESH_CLKS - 1);
    @(negedge clk);
    chkEq("R3 refresh repeats", txSet, 1);
  endtask

  task automatic tRxLatch();
    rxPulse(1'b1, 1'b0);
    chkEq("R4 set loads level", rxLevel, 1);
    chkEq("R4 set enables drive", rxDrive, 1);
    repeat (10) @(negedge clk);
    chkEq("R4 latch holds high", rxLevel, 1);
    rxPulse(1'b0, 1'b1);
    chkEq("R4 reset clears level", rxLevel, 0);
    chkEq("R4 reset keeps drive", rxDrive, 1);
    rxPulse(1'b1, 1'b0);
    chkEq("R4 set again", rxLevel, 1);
  endtask

  task automatic tConflict();
    rxPulse(1'b1, 1'b1);
    chkEq("R6 conflict keeps high", rxLevel, 1);
    chkEq("R6 conflict keeps drive", rxDrive, 1);
    rxPulse(1'b0, 1'b1);
    rxPulse(1'b1, 1'b1);
    chkEq("R6 conflict keeps low", rxLevel, 0);
  endtask

  task automatic tWatchdog();
    rxPulse(1'b1, 1'b0);
    repeat (WD_CLKS - 1) @(negedge clk);
    chkEq("R7 drive kept before limit", rxDrive, 1);
    @(negedge clk);
    chkEq("R7 drive dropped at limit", rxDrive, 0);
    chkEq("R7 level cleared at limit", rxLevel, 0);
    repeat (20) @(negedge clk);
    chkEq("R5 stays idle without pulse", rxDrive, 0);
    rxPulse(1'b1, 1'b1);
    chkEq("R5 conflict does not leave idle", rxDrive, 0);
    rxPulse(1'b1, 1'b0);
    chkEq("R5 valid pulse leaves idle", rxDrive, 1);
  endtask

  task automatic tNoRestart();
    rxPulse(1'b0, 1'b1);
    repeat (99) @(negedge clk);
    rxPulse(1'b1, 1'b1);
    repeat (WD_CLKS - 101) @(negedge clk);
    chkEq("R6 drive before original limit", rxDrive, 1);
    @(negedge clk);
    chkEq("R6 conflict did not restart watchdog", rxDrive, 0);
  endtask

  task automatic tLoop();
    int bad = 0;
    dataIn = 1'b0;
    loopEn = 1'b1;
    repeat (3) @(negedge clk);
    chkEq("R8 loop low drive up", rxDrive, 1);
    dataIn = 1'b1;
    @(negedge clk);
    chkEq("R8 level not yet after one edge", rxLevel, 0);
    @(negedge clk);
    chkEq("R8 level follows after two edges", rxLevel, 1);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!rxDrive || !rxLevel) bad++;
    end
    chkEq("R8 refresh keeps link alive", bad, 0);
    dataIn = 1'b0;
    repeat (2) @(negedge clk);
    chkEq("R8 level follows fall", rxLevel, 0);
    chkEq("R8 drive stays up", rxDrive, 1);
    loopEn = 1'b0;
    repeat (WD_CLKS + 5) @(negedge clk);
    chkEq("R7 far side lost drops drive", rxDrive, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run incomplete actual=timeout expected=done");
    finishRun();
  end

  initial begin
    tReset();
    tEdgesAndRefresh();
    tRxLatch();
    tConflict();
    tWatchdog();
    tNoRestart();
    tLoop();
    finishRun();
  end

endmodule